// File: doc/BRIEF.md
# Debug Memory CRC Engine

This block serves a debug controller. When a host wants to know whether its cached copy of target memory is still current, it asks the engine for a checksum of an address range. Transferring every byte over the slow debug link would take far longer. The engine requests the system memory bus and waits for the grant. It then reads the range one byte per access and keeps the bus until the last byte has come back. It folds each byte into a 16-bit CRC in the same cycle the byte arrives, so the run takes only as long as the reads themselves.

Two modes are offered. In whole-range mode a single CRC covers the entire range. In per-block mode the CRC restarts at every aligned 4096-byte block, and a result is emitted for each block the range touches. The host can then tell which blocks of a large invalidated cache actually changed. The final result of every command carries a last flag.

Top module: `dbg_crc_engine`

## Requirements
- R1: After reset, bus_req, mem_rd and res_valid are all low.
- R2: A cmd_start pulse with a nonzero cmd_len, seen while bus_req is low, raises bus_req from the next cycle. A cmd_start with cmd_len equal to zero, or one seen while bus_req is high, has no effect on the bus or the results.
- R3: A read (mem_rd high for one cycle) happens only while both bus_req and bus_gnt are high. Each read fetches a single byte. The read addresses run from cmd_addr upward by one and wrap modulo 2^ADDR_W. mem_rdata carries the byte in the cycle after the read.
- R4: While bus_gnt stays high, exactly one read is issued per cycle, and bus_req is high for exactly cmd_len + 1 cycles.
- R5: The CRC uses polynomial 0x1021 and starts at 0xFFFF. For each byte, data bits are taken from bit 0 up to bit 7. On each bit, the feedback is CRC bit 15 XOR the data bit. The register shifts left by one, and 0x1021 is XORed in when the feedback is 1. The result is not reflected or inverted.
- R6: In whole-range mode (cmd_per_blk low), a command produces exactly one result, with res_last high, covering every byte of the range.
- R7: In per-block mode, a result is produced after each byte whose address has its low 12 bits all ones. The CRC restarts at 0xFFFF for the next byte. A range starting mid-block yields a CRC of only its own bytes in that block.
- R8: The result for the final byte of a command has res_last high, whether or not that byte ends a 4096-byte block. Every other result has res_last low.
- R9: bus_req stays high from command acceptance until the final result is presented. It falls in the same cycle in which res_valid and res_last are both high.
- R10: res_valid is a single-cycle pulse. It appears one cycle after the data of the byte that closes a block or the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command strobe |
| cmd_addr | input | ADDR_W | First byte address of the range |
| cmd_len | input | LEN_W | Number of bytes in the range |
| cmd_per_blk | input | 1 | 1 selects one CRC per 4096-byte block |
| bus_req | output | 1 | Bus ownership request, high for the whole run |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rdata | input | 8 | Read byte, valid the cycle after mem_rd |
| res_valid | output | 1 | Result strobe |
| res_crc | output | 16 | Finished CRC value |
| res_last | output | 1 | Marks the final result of a command |

## Verification
The bench uses several command patterns, and each one separates a different kind of fault:
- A single byte shows whether the pipeline and result timing are right at the shortest length.
- A whole-range command that crosses a block boundary exposes a CRC wrongly restarted at 4096.
- Per-block ranges that start mid-block, end exactly on a boundary, span two full blocks or wrap past the top of the address space each exercise a different way of deciding where a block ends.
- A withheld and toggled grant separates reads gated by the grant from reads that merely count cycles.
- Zero-length and mid-run commands show whether the engine wrongly accepts them.

Memory contents are reseeded between runs so that stale results cannot match by chance.

// File: rtl/dbg_crc_pkg.sv
package dbg_crc_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } eng_state_t;

  // One byte, data bits consumed from bit 0 upward.
  function automatic logic [15:0] crc_byte(input logic [15:0] c_in,
                                           input logic [7:0]  d_in);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[15] ^ d_in[b];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/dbg_crc_addr_gen.sv
module dbg_crc_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              issue,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              final_byte
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              en;

  always_comb begin
    en     = load | issue;
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      addr_d = load_addr;
      left_d = load_len;
    end else if (issue) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign cur_addr   = addr_q;
  assign final_byte = (left_q == LEN_W'(1));

endmodule

// File: rtl/dbg_crc_accum.sv
module dbg_crc_accum
  import dbg_crc_pkg::*;
#(
  parameter int BLK_LOG2 = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                per_blk,
  input  logic                byte_vld,
  input  logic [7:0]          byte_data,
  input  logic [BLK_LOG2-1:0] byte_off,
  input  logic                byte_last,
  output logic                res_valid,
  output logic [15:0]         res_crc,
  output logic                res_last
);

  logic [15:0] crc_q, crc_d, crc_upd;
  logic        blk_end, crc_en, res_en;

  always_comb begin
    crc_upd = crc_byte(crc_q, byte_data);
    blk_end = byte_last | (per_blk & (&byte_off));
    crc_en  = clear | byte_vld;
    res_en  = byte_vld & blk_end;
    if (clear || blk_end) crc_d = CRC_INIT;
    else                  crc_d = crc_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else if (crc_en) crc_q <= crc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= res_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_crc  <= '0;
      res_last <= 1'b0;
    end else if (res_en) begin
      res_crc  <= crc_upd;
      res_last <= byte_last;
    end else begin
      res_last <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_crc_engine.sv
module dbg_crc_engine
  import dbg_crc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 17,
  parameter int BLK_LOG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_per_blk,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              res_valid,
  output logic [15:0]       res_crc,
  output logic              res_last
);

  eng_state_t          st_q, st_d;
  logic                accept, issue, final_byte;
  logic                per_q, rd_q, last_q;
  logic [BLK_LOG2-1:0] off_q;

  assign accept = (st_q == ST_IDLE) && cmd_start && (cmd_len != '0);
  assign issue  = (st_q == ST_RUN) && bus_gnt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_RUN;
      ST_RUN:   if (issue && final_byte) st_d = ST_DRAIN;
      ST_DRAIN: if (rd_q && last_q) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= 1'b0;
    else if (accept) per_q <= cmd_per_blk;
  end

  // One-cycle read return pipeline.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      last_q <= 1'b0;
      off_q  <= '0;
    end else begin
      rd_q   <= issue;
      last_q <= issue & final_byte;
      if (issue) off_q <= mem_addr[BLK_LOG2-1:0];
    end
  end

  dbg_crc_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_addr  (cmd_addr),
    .load_len   (cmd_len),
    .issue      (issue),
    .cur_addr   (mem_addr),
    .final_byte (final_byte)
  );

  dbg_crc_accum #(.BLK_LOG2(BLK_LOG2)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .per_blk   (per_q),
    .byte_vld  (rd_q),
    .byte_data (mem_rdata),
    .byte_off  (off_q),
    .byte_last (last_q),
    .res_valid (res_valid),
    .res_crc   (res_crc),
    .res_last  (res_last)
  );

  assign bus_req = (st_q != ST_IDLE);
  assign mem_rd  = issue;

endmodule

// File: rtl/dbg_crc_engine_chk.sv
module dbg_crc_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              res_valid,
  input logic              res_last
);

  // R3
  rd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_gnt && bus_req));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && bus_req) |=> (mem_rd |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

  // R9
  release_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (res_valid && res_last));

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid || !$past(res_last));

  // R8
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_last |-> res_valid);

endmodule

bind dbg_crc_engine dbg_crc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .res_valid (res_valid),
  .res_last  (res_last)
);

// File: tb/dbg_crc_engine_tb.sv
`timescale 1ns/1ps
module dbg_crc_engine_tb;

  localparam int AW = 16;
  localparam int LW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_start, cmd_per_blk, bus_gnt;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic          bus_req, mem_rd, res_valid, res_last;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic [15:0]   res_crc;

  always #4 clk = ~clk;

  dbg_crc_engine #(.ADDR_W(AW), .LEN_W(LW), .BLK_LOG2(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_per_blk(cmd_per_blk), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_crc(res_crc),
    .res_last(res_last));

  int   total = 0;
  int   bad   = 0;
  bit   done_flag = 0;
  int   seed = 0;

  // reference model state
  int   exp_crc[$];
  int   exp_last[$];
  bit   model_active = 0;
  int   exp_addr = 0;
  int   reads_left = 0;
  int   req_cycles = 0;

  function automatic int mem_byte(int a);
    return ((a * 37) ^ (a >> 8) ^ seed) & 255;
  endfunction

  function automatic int ref_crc(int c, int d);
    for (int i = 0; i < 8; i++) begin
      int bitv;
      bitv = ((c >> 15) & 1) ^ ((d >> i) & 1);
      c = (c << 1) & 16'hFFFF;
      if (bitv != 0) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory: byte returned the cycle after the read
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= 8'(mem_byte(int'(mem_addr)));
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && model_active) begin
      if (mem_rd) begin
        chk(bus_gnt == 1'b1, "R3 read without grant", int'(bus_gnt), 1);
        chk(int'(mem_addr) == exp_addr, "R3 read address", int'(mem_addr), exp_addr);
        chk(reads_left > 0, "R4 extra read", reads_left, 1);
        exp_addr   = (exp_addr + 1) & 16'hFFFF;
        reads_left = reads_left - 1;
      end
      if (res_valid) begin
        if (exp_crc.size() == 0) begin
          chk(1'b0, "R7 unexpected result", int'(res_crc), 0);
        end else begin
          int ec, el;
          ec = exp_crc.pop_front();
          el = exp_last.pop_front();
          chk(int'(res_crc) == ec, "R5 crc value", int'(res_crc), ec);
          chk(int'(res_last) == el, "R8 last flag", int'(res_last), el);
          if (el != 0) model_active = 0;
        end
      end
    end else if (rst_n) begin
      chk(mem_rd == 1'b0, "R2 read while idle", int'(mem_rd), 0);
      chk(res_valid == 1'b0, "R2 result while idle", int'(res_valid), 0);
    end
    if (rst_n) begin
      chk(bus_req == model_active, "R9 bus_req", int'(bus_req), int'(model_active));
      if (bus_req) req_cycles++;
    end
  end

  task automatic build_expect(int addr, int len, bit per);
    int c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      int a;
      a = (addr + i) & 16'hFFFF;
      c = ref_crc(c, mem_byte(a));
      if (i == len - 1) begin
        exp_crc.push_back(c); exp_last.push_back(1);
      end else if (per && ((a & 12'hFFF) == 12'hFFF)) begin
        exp_crc.push_back(c); exp_last.push_back(0);
        c = 16'hFFFF;
      end
    end
  endtask

  task automatic start_cmd(int addr, int len, bit per);
    build_expect(addr, len, per);
    exp_addr   = addr;
    reads_left = len;
    req_cycles = 0;
    @(posedge clk); #1;
    cmd_start = 1; cmd_addr = AW'(addr); cmd_len = LW'(len); cmd_per_blk = per;
    @(posedge clk);
    model_active = (len != 0);
    #1 cmd_start = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (model_active && n < 20000) begin
      @(posedge clk); n++;
    end
    @(negedge clk);
    chk(exp_crc.size() == 0, req, exp_crc.size(), 0);
    chk(reads_left == 0, "R3 all bytes read", reads_left, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_start = 0; cmd_addr = '0; cmd_len = '0; cmd_per_blk = 0;
    bus_gnt = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!bus_req && !mem_rd && !res_valid, "R1 reset state",
        int'({bus_req, mem_rd, res_valid}), 0);

    // R10, R4: single byte
    start_cmd(16'h0010, 1, 0);
    wait_done("R10 single byte result");
    chk(req_cycles == 2, "R4 bus_req span len=1", req_cycles, 2);

    // R6: whole range crossing a block boundary
    seed = 5;
    start_cmd(16'h0FF0, 300, 0);
    wait_done("R6 one result for whole range");
    chk(req_cycles == 301, "R4 bus_req span len=300", req_cycles, 301);

    // R7, R8: per-block starting mid-block, partial tail
    seed = 17;
    start_cmd(16'h0FF0, 16'h30, 1);
    wait_done("R7 two block results");

    // R8: ends exactly on a boundary
    start_cmd(16'h1F00, 16'h100, 1);
    wait_done("R8 boundary end single result");

    // R7: two full blocks
    seed = 99;
    start_cmd(16'h2000, 16'h2000, 1);
    wait_done("R7 two full blocks");
    chk(req_cycles == 16'h2001, "R4 bus_req span 8192", req_cycles, 16'h2001);

    // R3: wrap past top of address space
    seed = 3;
    start_cmd(16'hFFF8, 16, 1);
    wait_done("R3 wrap results");

    // R3: grant withheld then toggled
    bus_gnt = 0;
    start_cmd(16'h0100, 40, 1);
    repeat (6) @(posedge clk);
    #1;
    for (int k = 0; k < 20; k++) begin
      bus_gnt = ~bus_gnt;
      @(posedge clk); #1;
    end
    bus_gnt = 1;
    wait_done("R3 gated by grant");

    // R2: zero length ignored
    start_cmd(16'h0200, 0, 0);
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R2 zero length ignored", int'(bus_req), 0);

    // R2: start while busy ignored
    seed = 41;
    start_cmd(16'h0300, 64, 0);
    repeat (10) @(posedge clk);
    #1 cmd_start = 1; cmd_addr = 16'h7000; cmd_len = 17'd5; cmd_per_blk = 1;
    @(posedge clk); #1 cmd_start = 0;
    wait_done("R2 busy start ignored");
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R2 no queued command", int'(bus_req), 0);

    finish_run();
  end

endmodule